// File: doc/BRIEF.md
# Edge-Triggered Priority Interrupt Controller

This block collects interrupt requests from eight input lines and presents them to one processor. Each line has its own edge catcher. A rising edge on an armed line latches a pending request. The line then stays deaf to further edges until two things have happened: it has gone low, and its latched request has been cleared. A fixed-priority resolver compares the pending requests against an in-service register and a mask. It raises the processor interrupt output only when the best unmasked pending request outranks everything currently being serviced.

The processor answers with a two-step acknowledge. The first pulse moves the winning request from pending to in-service. The second pulse makes the block present a vector code, formed from a programmable base and the three-bit level number. A request can be withdrawn before the first step, because its line drops while the request is still pending. In that case the first step finds nothing to serve. The block then answers with the lowest-priority level and marks nothing as in service, so software can tell this answer apart from a real request on that level.

A small command port writes the mask, writes the vector base, and issues a specific end-of-interrupt. The end-of-interrupt clears one chosen in-service bit. It only lifts priority blocking and plays no part in edge detection.

Top module: `edge_irq_ctrl`

## Requirements
- R1: A rising edge seen on an armed line sets that line's pending request. If the request is unmasked, its line is still high and nothing in service blocks it, `int_o` is high after the clock edge that sampled the rise.
- R2: Once a line has latched a request, further rising edges on it are ignored. The line re-arms only after its pending request has been cleared and the line has been sampled low.
- R3: The first `inta_i` pulse clears the pending bit of the forwarded level and sets its in-service bit, so `int_o` drops. The second pulse makes `vec_valid_o` high for exactly one cycle, one clock later, with the vector on `vec_o`.
- R4: Priority is fixed: level 0 is the highest and level 7 the lowest. The lowest-numbered eligible request is the one served.
- R5: While an in-service bit is set, requests at that level and at every lower-priority level are not forwarded. Requests at higher priority still raise `int_o`.
- R6: Command code 2'b11 is a specific end-of-interrupt. It clears the in-service bit numbered by `cmd_data_i[2:0]`. It does not affect whether edges are latched.
- R7: Command code 2'b01 loads the mask from `cmd_data_i`, where bit i set to 1 blocks level i from forwarding. A masked line still latches edges.
- R8: If the first acknowledge step finds no request to forward, the vector carries level 7 and no in-service bit is set. Every pending request whose line is low at that step is cleared.
- R9: After reset, nothing is pending, nothing is in service, the mask and base are zero, every line is armed, and `int_o` and `vec_valid_o` are low.
- R10: Command code 2'b10 loads the vector base from `cmd_data_i[4:0]`, and `vec_o` is {base, level}. Command code 2'b00 changes nothing.

Command port codes are the ones given in R6, R7 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | 8 | Interrupt request lines, already synchronous to clk |
| inta_i | input | 1 | Acknowledge pulse from the processor, one per step |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code |
| cmd_data_i | input | 8 | Command data |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector presented this cycle |
| vec_o | output | 8 | Vector code {base, level} |

## Verification
The assertions take for granted that the request lines are already synchronous to the clock. They also assume the acknowledge pulses come in pairs, with the first step of one pair never issued in the middle of another, and that the end-of-interrupt data names a level that exists. The stimulus changes inputs only on the falling clock edge and always issues acknowledges as complete two-pulse sequences. It drops and re-raises lines to exercise arming, withdrawal and the spurious answer within those limits.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_MASK = 2'b01,
    CMD_BASE = 2'b10,
    CMD_EOI  = 2'b11
  } cmd_op_e;

  typedef enum logic {
    ACK_IDLE = 1'b0,
    ACK_VEC  = 1'b1
  } ack_st_e;

endpackage

// File: rtl/edge_irq_line.sv
module edge_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clr_i,
  output logic req_o
);

  logic line_q, armed_q, req_q;
  logic line_d, armed_d, req_d;
  logic rise, latch;

  always_comb begin
    rise    = line_i & ~line_q;
    latch   = armed_q & rise;
    line_d  = line_i;
    if (armed_q) armed_d = ~latch;
    else         armed_d = ~line_i & ~req_q;
    if (latch)      req_d = 1'b1;
    else if (clr_i) req_d = 1'b0;
    else            req_d = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      armed_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      line_q  <= line_d;
      armed_q <= armed_d;
      req_q   <= req_d;
    end
  end

  assign req_o = req_q;

  assert_edge_latches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && line_i && !line_q) |=> req_q);

  assert_req_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !clr_i) |=> req_q);

endmodule

// File: rtl/edge_irq_prio.sv
module edge_irq_prio #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  line_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  isr_i,
  output logic          fwd_o,
  output logic [LW-1:0] win_o
);

  logic [N-1:0]  elig;
  logic          found, isr_any;
  logic [LW-1:0] win, top;

  always_comb begin
    elig    = req_i & line_i & ~mask_i;
    found   = 1'b0;
    win     = '0;
    isr_any = 1'b0;
    top     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        win   = LW'(i);
      end
      if (isr_i[i]) begin
        isr_any = 1'b1;
        top     = LW'(i);
      end
    end
    fwd_o = found && (!isr_any || (win < top));
    win_o = win;
  end

endmodule

// File: rtl/edge_irq_ack.sv
module edge_irq_ack
  import edge_irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = 3,
  parameter int BW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inta_i,
  input  logic           fwd_i,
  input  logic [LW-1:0]  win_i,
  input  logic [N-1:0]   line_i,
  input  logic [N-1:0]   req_i,
  input  logic           eoi_v_i,
  input  logic [LW-1:0]  eoi_lvl_i,
  input  logic [BW-1:0]  base_i,
  output logic [N-1:0]   clr_o,
  output logic [N-1:0]   isr_o,
  output logic           vec_valid_o,
  output logic [BW+LW-1:0] vec_o
);

  localparam logic [LW-1:0] SPUR = LW'(N - 1);

  ack_st_e          st_q, st_d;
  logic [LW-1:0]    lvl_q, lvl_d;
  logic [N-1:0]     isr_q, isr_d;
  logic             vv_q, vv_d;
  logic [BW+LW-1:0] vec_q, vec_d;
  logic [N-1:0]     set_m, eoi_m;
  logic             step1, step2;

  always_comb begin
    step1 = inta_i && (st_q == ACK_IDLE);
    step2 = inta_i && (st_q == ACK_VEC);
    st_d  = st_q;
    lvl_d = lvl_q;
    clr_o = '0;
    set_m = '0;
    eoi_m = '0;
    if (step1) begin
      st_d = ACK_VEC;
      if (fwd_i) begin
        clr_o[win_i] = 1'b1;
        set_m[win_i] = 1'b1;
        lvl_d        = win_i;
      end else begin
        clr_o = req_i & ~line_i;
        lvl_d = SPUR;
      end
    end
    if (step2) st_d = ACK_IDLE;
    if (eoi_v_i) eoi_m[eoi_lvl_i] = 1'b1;
    isr_d = (isr_q & ~eoi_m) | set_m;
    vv_d  = step2;
    vec_d = step2 ? {base_i, lvl_q} : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ACK_IDLE;
      lvl_q <= '0;
      isr_q <= '0;
      vv_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
      isr_q <= isr_d;
      vv_q  <= vv_d;
      vec_q <= vec_d;
    end
  end

  assign isr_o       = isr_q;
  assign vec_valid_o = vv_q;
  assign vec_o       = vec_q;

  assert_single_isr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_q & ~$past(isr_q)));

  assert_vec_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);

  assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_v_i && !step1) |=> !isr_q[$past(eoi_lvl_i)]);

  assert_spurious_no_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step1 && !fwd_i && !eoi_v_i) |=> (isr_q == $past(isr_q)));

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int BW = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             irq_i,
  input  logic                     inta_i,
  input  logic                     cmd_valid_i,
  input  logic [1:0]               cmd_op_i,
  input  logic [N-1:0]             cmd_data_i,
  output logic                     int_o,
  output logic                     vec_valid_o,
  output logic [BW+$clog2(N)-1:0]  vec_o
);

  localparam int LW = $clog2(N);

  logic          rs1_q, rs2_q, rst_sync_n;
  logic [N-1:0]  mask_q, mask_d;
  logic [BW-1:0] base_q, base_d;
  logic [N-1:0]  req, clr, isr;
  logic          fwd;
  logic [LW-1:0] win;
  logic          eoi_v;
  cmd_op_e       op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  always_comb begin
    op     = cmd_op_e'(cmd_op_i);
    mask_d = mask_q;
    base_d = base_q;
    eoi_v  = 1'b0;
    if (cmd_valid_i) begin
      case (op)
        CMD_MASK: mask_d = cmd_data_i;
        CMD_BASE: base_d = cmd_data_i[BW-1:0];
        CMD_EOI:  eoi_v  = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else begin
      mask_q <= mask_d;
      base_q <= base_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    edge_irq_line u_line (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .line_i (irq_i[g]),
      .clr_i  (clr[g]),
      .req_o  (req[g])
    );
  end

  edge_irq_prio #(.N(N), .LW(LW)) u_prio (
    .req_i  (req),
    .line_i (irq_i),
    .mask_i (mask_q),
    .isr_i  (isr),
    .fwd_o  (fwd),
    .win_o  (win)
  );

  edge_irq_ack #(.N(N), .LW(LW), .BW(BW)) u_ack (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .inta_i      (inta_i),
    .fwd_i       (fwd),
    .win_i       (win),
    .line_i      (irq_i),
    .req_i       (req),
    .eoi_v_i     (eoi_v),
    .eoi_lvl_i   (cmd_data_i[LW-1:0]),
    .base_i      (base_q),
    .clr_o       (clr),
    .isr_o       (isr),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o)
  );

  assign int_o = fwd;

  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int_o |-> |(req & irq_i & ~mask_q));

  assert_int_drops_after_step_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int_o && inta_i && !vec_valid_o && $stable(irq_i)) |-> ##1 (isr != '0));

endmodule

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       inta = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic       int_o, vec_valid_o;
  logic [7:0] vec_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .inta_i(inta),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_data_i(cmd_data),
    .int_o(int_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  // behavioural reference
  bit [7:0] m_line, m_armed, m_irr, m_isr, m_mask;
  bit [4:0] m_base;
  bit       m_st, m_vv;
  int       m_lvl;
  bit [7:0] m_vec;

  function automatic int m_fwd();
    int w, t;
    w = -1; t = 8;
    for (int i = 7; i >= 0; i--) begin
      if (m_irr[i] && irq[i] && !m_mask[i]) w = i;
      if (m_isr[i]) t = i;
    end
    if (w >= 0 && w < t) return w;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = '0; m_armed = '1; m_irr = '0; m_isr = '0; m_mask = '0;
      m_base = '0; m_st = 0; m_vv = 0; m_lvl = 0; m_vec = '0;
    end else begin
      int f;
      bit [7:0] n_irr, n_isr, n_armed;
      f = m_fwd();
      n_irr = m_irr; n_isr = m_isr; n_armed = m_armed;
      m_vv = 0;
      if (cmd_valid) begin
        if (cmd_op == 2'b11) n_isr[cmd_data[2:0]] = 0;
      end
      if (inta) begin
        if (!m_st) begin
          if (f >= 0) begin
            n_irr[f] = 0; n_isr[f] = 1; m_lvl = f;
          end else begin
            m_lvl = 7;
            for (int i = 0; i < 8; i++) if (m_irr[i] && !irq[i]) n_irr[i] = 0;
          end
          m_st = 1;
        end else begin
          m_vv = 1; m_vec = {m_base, 3'(m_lvl)}; m_st = 0;
        end
      end
      for (int i = 0; i < 8; i++) begin
        if (m_armed[i]) begin
          if (irq[i] && !m_line[i]) begin n_irr[i] = 1; n_armed[i] = 0; end
        end else if (!irq[i] && !m_irr[i]) n_armed[i] = 1;
      end
      if (cmd_valid && cmd_op == 2'b01) m_mask = cmd_data;
      if (cmd_valid && cmd_op == 2'b10) m_base = cmd_data[4:0];
      m_irr = n_irr; m_isr = n_isr; m_armed = n_armed; m_line = irq;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("model(R1,R3,R5) int_o", {7'd0, int_o}, {7'd0, (m_fwd() >= 0)});
    chk("model(R3) vec_valid_o", {7'd0, vec_valid_o}, {7'd0, m_vv});
    if (m_vv) chk("model(R10) vec_o", vec_o, m_vec);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] d);
    cmd_valid = 1; cmd_op = op; cmd_data = d;
    step();
    cmd_valid = 0; cmd_op = 0; cmd_data = 0;
  endtask

  task automatic ack(output logic [7:0] v);
    inta = 1;
    step();
    step();
    v = vec_o;
    inta = 0;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();
    chk("R9 int_o after reset", {7'd0, int_o}, 8'd0);
    chk("R9 vec_valid after reset", {7'd0, vec_valid_o}, 8'd0);

    cmd(2'b10, 8'h12);          // R10 base
    cmd(2'b00, 8'hff);          // R10 no-op must not mask
    irq[3] = 1; step();
    chk("R1 int_o after edge", {7'd0, int_o}, 8'd1);
    inta = 1; step();
    chk("R3 int_o drops after step one", {7'd0, int_o}, 8'd0);
    step();
    chk("R3 vec_valid on step two", {7'd0, vec_valid_o}, 8'd1);
    chk("R10 vector base and level", vec_o, 8'h93);
    inta = 0; step();
    chk("R3 vec_valid single cycle", {7'd0, vec_valid_o}, 8'd0);

    irq[3] = 0; step(); irq[3] = 1; step(); step();
    chk("R5 in-service blocks same level", {7'd0, int_o}, 8'd0);
    cmd(2'b11, 8'd3);
    chk("R2 re-armed after ack and low / R6 eoi", {7'd0, int_o}, 8'd1);
    ack(v); chk("R2 second request vector", v, 8'h93);
    irq[3] = 0; cmd(2'b11, 8'd3); step();

    irq[5] = 1; step(); irq[5] = 0; step(); irq[5] = 1; step();
    ack(v); chk("R2 latched request served", v, 8'h95);
    cmd(2'b11, 8'd5); step();
    chk("R2 edge while pending ignored", {7'd0, int_o}, 8'd0);
    irq[5] = 0; step(); step();

    irq[6] = 1; irq[2] = 1; step();
    ack(v); chk("R4 lowest level wins", v, 8'h92);
    chk("R5 lower level blocked", {7'd0, int_o}, 8'd0);
    irq[1] = 1; step();
    chk("R5 higher level passes", {7'd0, int_o}, 8'd1);
    ack(v); chk("R4 level one vector", v, 8'h91);
    cmd(2'b11, 8'd1);
    chk("R6 level two still blocks", {7'd0, int_o}, 8'd0);
    cmd(2'b11, 8'd2);
    chk("R6 eoi unblocks pending", {7'd0, int_o}, 8'd1);
    ack(v); chk("R4 level six vector", v, 8'h96);
    irq = '0; cmd(2'b11, 8'd6); step(); step();

    cmd(2'b01, 8'h08);
    irq[3] = 1; step(); step();
    chk("R7 masked not forwarded", {7'd0, int_o}, 8'd0);
    cmd(2'b01, 8'h00);
    chk("R7 latched while masked", {7'd0, int_o}, 8'd1);
    ack(v); chk("R7 vector after unmask", v, 8'h93);
    irq[3] = 0; cmd(2'b11, 8'd3); step();

    irq[5] = 1; step();
    chk("R1 level five raised", {7'd0, int_o}, 8'd1);
    irq[5] = 0; step();
    chk("R8 withdrawn drops int_o", {7'd0, int_o}, 8'd0);
    ack(v); chk("R8 spurious vector level 7", v, 8'h97);
    irq[7] = 1; step();
    chk("R8 real level 7 not blocked", {7'd0, int_o}, 8'd1);
    ack(v); chk("R8 real level 7 vector", v, 8'h97);
    irq[5] = 1; step();
    chk("R8 withdrawn line re-armed", {7'd0, int_o}, 8'd1);
    ack(v); chk("R8 level five after spurious", v, 8'h95);
    irq = '0; cmd(2'b11, 8'd5); cmd(2'b11, 8'd7); step(); step();
    chk("R6 all cleared", {7'd0, int_o}, 8'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule